// File: doc/BRIEF.md
# Broadcast Register Bus Slave

This block is the slave end of a synchronous 16-bit bus that carries both address and data. It gives access to five register banks: four identical per-channel banks and one shared bank. Every transaction opens with one address cycle. That cycle is followed by any number of data cycles, for as long as the select line stays high. The address word sets three things: the direction, which banks take part, and whether the data cycles repeat one register or loop through a window of registers.

A write lands in the addressed register of every enabled bank in the same clock. This lets several channels be programmed with one transaction. A read returns the bitwise OR of the addressed register across the enabled banks, which lets software poll status from a group of channels at once. The bus is modelled as separate input, output and output-enable ports, so that a pad ring can build the shared tristate line outside the block.

Top module: `bcast_csr_bus`

## Requirements
- R1: After synchronous active-low reset, every register in every bank reads zero. `bus_oe` is low, and `bus_out` is zero whenever `bus_oe` is low.
- R2: The first rising edge with `sel` high after idle is the address cycle. On that edge `bus_in` is captured as the address word, and no register is written and no read data is produced. The address word fields are: bit 15 = burst, bit 14 = shared-bank enable, bits 13..10 = channel 3..0 enables, bits 9:5 = stop address, bits 4:0 = start/register address.
- R3: A write data cycle stores `bus_in` into the addressed register of every enabled bank on the same edge. Channel banks hold addresses 0..15. The shared bank holds addresses 16..31.
- R4: A read data cycle places the OR of the addressed register from all enabled banks on `bus_out` with `bus_oe` high. This happens one cycle later, that is, after the edge that ends that data cycle.
- R5: With no bank enable set, a write changes no register and a read returns zero.
- R6: In single mode (bit 15 = 0) the stop field is ignored. Every data cycle of the transaction accesses the register given by bits 4:0.
- R7: In burst mode each data cycle advances to the next address, up to and including the stop address. The cycle after the stop address accesses the start address again.
- R8: In burst mode with a stop address below the start address, the address counts through 31, wraps to 0 and continues up to the stop address.
- R9: An access to an address outside a bank's range does not change that bank and adds zero to the read OR.
- R10: A low `sel` at a rising edge ends the transaction. `bus_oe` is low after that edge, and the next cycle with `sel` high is again an address cycle.
- R11: The direction is taken from `wr_n` in the address cycle (1 = read, 0 = write) and held for the whole transaction. Changes of `wr_n` during data cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all bus activity is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Transaction strobe; high while a transaction is in progress |
| wr_n | input | 1 | Direction in the address cycle: 1 = read, 0 = write |
| bus_in | input | 16 | Incoming half of the shared bus (address word or write data) |
| bus_out | output | 16 | Outgoing half of the shared bus (read data) |
| bus_oe | output | 1 | High when the block is to drive the shared bus |

## Verification
The bench covers four groups of cases. The first is wrap behaviour: a burst longer than its window, and a burst whose stop address lies below its start address. A design that stopped, ran on linearly or failed to pass 31 would leave the wrong words in the registers. The second is mask corner cases: an empty enable set, a channel enable pointed at a shared-bank address, and multi-bank reads with overlapping bits. In these cases a faulty merge would show stray bits or dropped bits. The third is a single-mode header carrying a non-zero stop field and several data cycles, which catches an address that advances when it should not. The fourth is a flip of `wr_n` in mid-transaction. A design that re-sampled the direction would stop writing and would drive the bus.

// File: rtl/bcast_csr_pkg.sv
// Package: shared constants and the address-word layout for the broadcast
// register bus. Assumes a 16-bit bus and 5-bit register addresses.
package bcast_csr_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 5;
    localparam int N_CH   = 4;
    localparam int N_BANK = N_CH + 1;   // channel banks plus the shared bank
    localparam int COM_IX = N_CH;       // index of the shared bank in bank vectors

    // Address word; member order follows the bit positions 15 down to 0.
    typedef struct packed {
        logic              burst;
        logic              com_en;
        logic [N_CH-1:0]   ch_en;
        logic [ADDR_W-1:0] stop;
        logic [ADDR_W-1:0] start;
    } hdr_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_DATA = 1'b1} seq_st_e;
endpackage

// File: rtl/bcast_csr_seq.sv
// Module: bcast_csr_seq
// Transaction sequencer. Captures the address word on the first selected
// cycle, holds the direction, and produces the register address for each
// data cycle (fixed in single mode, looping start..stop in burst mode).
// Assumes sel stays high for the whole transaction.
module bcast_csr_seq
    import bcast_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic [BUS_W-1:0]  bus_in,
    output hdr_t              hdr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              dir_rd,
    output logic              in_data,
    output logic              wr_stb,
    output logic              rd_stb
);
    seq_st_e st_q;

    // State, header capture and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            hdr      <= '0;
            cur_addr <= '0;
            dir_rd   <= 1'b0;
        end else if (!sel) begin
            st_q <= ST_IDLE;
        end else if (st_q == ST_IDLE) begin
            st_q     <= ST_DATA;
            hdr      <= hdr_t'(bus_in);
            cur_addr <= bus_in[ADDR_W-1:0];
            dir_rd   <= wr_n;
        end else if (hdr.burst) begin
            cur_addr <= (cur_addr == hdr.stop) ? hdr.start : cur_addr + 1'b1;
        end
    end

    // Per-cycle access strobes for the data phase.
    always_comb begin
        in_data = (st_q == ST_DATA);
        wr_stb  = in_data && sel && !dir_rd;
        rd_stb  = in_data && sel && dir_rd;
    end
endmodule

// File: rtl/bcast_csr_bank.sv
// Module: bcast_csr_bank
// One register bank covering addresses BASE..BASE+DEPTH-1 of the 5-bit
// space. Writes outside the range are dropped; reads outside return zero.
// Assumes BASE+DEPTH <= 32 and DEPTH a power of two.
module bcast_csr_bank
    import bcast_csr_pkg::*;
#(
    parameter int BASE  = 0,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OFF_W = ADDR_W + 1;

    logic [BUS_W-1:0] mem [DEPTH];
    logic [OFF_W-1:0] off;
    logic             hit;
    logic [IDX_W-1:0] idx;

    // Range decode: offset from base, underflow lands outside the window.
    always_comb begin
        off   = {1'b0, addr} - OFF_W'(BASE);
        hit   = (off < OFF_W'(DEPTH));
        idx   = off[IDX_W-1:0];
        rdata = hit ? mem[idx] : '0;
    end

    // Register storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && hit) begin
            mem[idx] <= wdata;
        end
    end
endmodule

// File: rtl/bcast_csr_bus.sv
// Module: bcast_csr_bus (top)
// Slave interface of a multiplexed address/data register bus with four
// channel banks and one shared bank. Writes broadcast to enabled banks;
// reads return the OR of enabled banks, registered one cycle later.
// Assumes an external tristate buffer built from bus_out and bus_oe.
module bcast_csr_bus
    import bcast_csr_pkg::*;
#(
    parameter int CH_DEPTH  = 16,
    parameter int COM_BASE  = 16,
    parameter int COM_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);
    hdr_t              hdr_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              dir_rd;
    logic              in_data;
    logic              wr_stb;
    logic              rd_stb;
    logic [N_BANK-1:0] bank_en;
    logic [BUS_W-1:0]  bank_rd [N_BANK];
    logic [BUS_W-1:0]  merged;
    logic [BUS_W-1:0]  rd_q;
    logic              oe_q;
    logic              hdr_burst;
    logic [ADDR_W-1:0] hdr_start;
    logic [ADDR_W-1:0] hdr_stop;

    bcast_csr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_n     (wr_n),
        .bus_in   (bus_in),
        .hdr      (hdr_q),
        .cur_addr (cur_addr),
        .dir_rd   (dir_rd),
        .in_data  (in_data),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb)
    );

    // Bank enable vector and header fields brought out for the checker.
    always_comb begin
        bank_en   = {hdr_q.com_en, hdr_q.ch_en};
        hdr_burst = hdr_q.burst;
        hdr_start = hdr_q.start;
        hdr_stop  = hdr_q.stop;
    end

    genvar g;
    generate
        for (g = 0; g < N_BANK; g++) begin : g_bank
            localparam int B_BASE  = (g == COM_IX) ? COM_BASE  : 0;
            localparam int B_DEPTH = (g == COM_IX) ? COM_DEPTH : CH_DEPTH;
            bcast_csr_bank #(
                .BASE  (B_BASE),
                .DEPTH (B_DEPTH)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_stb && bank_en[g]),
                .addr  (cur_addr),
                .wdata (bus_in),
                .rdata (bank_rd[g])
            );
        end
    endgenerate

    // OR-merge of the addressed word over every enabled bank.
    always_comb begin
        merged = '0;
        for (int i = 0; i < N_BANK; i++) begin
            if (bank_en[i]) merged = merged | bank_rd[i];
        end
    end

    // Registered read return and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            oe_q <= 1'b0;
        end else if (rd_stb) begin
            rd_q <= merged;
            oe_q <= 1'b1;
        end else begin
            rd_q <= '0;
            oe_q <= 1'b0;
        end
    end

    assign bus_out = rd_q;
    assign bus_oe  = oe_q;
endmodule

// File: rtl/bcast_csr_chk.sv
// Module: bcast_csr_chk
// Protocol checker bound into bcast_csr_bus. Observes the bus ports and the
// sequencer state; holds no design logic.
module bcast_csr_chk
    import bcast_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              bus_oe,
    input logic [BUS_W-1:0]  bus_out,
    input logic              in_data,
    input logic              dir_rd,
    input logic              burst,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] stop_addr
);
    // R1: bus output is quiet whenever not driving.
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_out == '0);

    // R2: the address cycle never yields read data.
    a_r2_addr_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !in_data) |=> !bus_oe);

    // R10: dropping the strobe releases the bus after the next edge.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !bus_oe);

    // R11: direction holds across data cycles.
    a_r11_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && $past(in_data)) |-> $stable(dir_rd));

    // R6: single mode keeps the register address fixed.
    a_r6_single_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !burst && $past(in_data)) |-> $stable(cur_addr));

    // R7: after the stop address, burst returns to the start address.
    a_r7_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && burst && $past(in_data && sel && (cur_addr == stop_addr)))
        |-> cur_addr == start_addr);
endmodule

bind bcast_csr_bus bcast_csr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .bus_oe     (bus_oe),
    .bus_out    (bus_out),
    .in_data    (in_data),
    .dir_rd     (dir_rd),
    .burst      (hdr_burst),
    .cur_addr   (cur_addr),
    .start_addr (hdr_start),
    .stop_addr  (hdr_stop)
);

// File: tb/bcast_csr_bus_tb.sv
`timescale 1ns/1ps
module bcast_csr_bus_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] wbuf [8];
    logic [15:0] rbuf [8];
    logic        obuf [8];

    always #2 clk = ~clk;   // 250 MHz

    bcast_csr_bus u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_n    (wr_n),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    // Vector: write header, write data, read header, expected read word.
    localparam logic [63:0] VECS [9] = '{
        64'h0403_00F0_0403_00F0,  // R3 single channel write
        64'h1003_0F01_1403_0FF1,  // R4 OR of two channels
        64'h3C05_A5A5_2005_A5A5,  // R3 broadcast to all channels
        64'h0805_0A5A_3C05_AFFF,  // R4 OR of four channels
        64'h4011_1234_4011_1234,  // R3 shared bank
        64'h4411_00FF_0411_0000,  // R9 channel bank ignores shared address
        64'h0011_FFFF_4011_00FF,  // R5 empty mask write has no effect
        64'h07E7_7777_0407_7777,  // R6 stop field ignored in single mode
        64'h0007_FFFF_0007_0000   // R5 empty mask read returns zero
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transaction: address cycle, n data cycles, then strobe low.
    task automatic txn(input logic [15:0] hdr, input logic is_rd, input int n,
                       input logic flip);
        @(negedge clk);
        sel = 1'b1; wr_n = is_rd; bus_in = hdr;
        @(posedge clk); #1;
        chk("R2 no drive after address cycle", {15'd0, bus_oe}, 16'd0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_in = is_rd ? 16'h0000 : wbuf[i];
            if (flip) wr_n = ~is_rd;
            @(posedge clk); #1;
            rbuf[i] = bus_out;
            obuf[i] = bus_oe;
        end
        @(negedge clk);
        sel = 1'b0; wr_n = 1'b1; bus_in = '0;
        @(posedge clk); #1;
        chk("R10 release after strobe low", {15'd0, bus_oe}, 16'd0);
    endtask

    task automatic rd1(input logic [15:0] hdr, input string req, input logic [15:0] exp);
        txn(hdr, 1'b1, 1, 1'b0);
        chk(req, rbuf[0], exp);
        chk("R4 drive during read return", {15'd0, obuf[0]}, 16'd1);
    endtask

    task automatic wr1(input logic [15:0] hdr, input logic [15:0] d);
        wbuf[0] = d;
        txn(hdr, 1'b0, 1, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 oe low in reset", {15'd0, bus_oe}, 16'd0);
        chk("R1 out zero in reset", bus_out, 16'd0);
        @(negedge clk); rst_n = 1'b1;
        rd1(16'h7C03, "R1 registers clear after reset", 16'h0000);
        rd1(16'h4010, "R1 shared register clear after reset", 16'h0000);

        for (int v = 0; v < 9; v++) begin
            logic [63:0] e;
            e = VECS[v];
            wr1(e[63:48], e[47:32]);
            rd1(e[31:16], $sformatf("vector %0d (see table tag)", v), e[15:0]);
        end

        // R6: repeated data cycles in single mode hit one register.
        wbuf[0] = 16'h1111; wbuf[1] = 16'h2222;
        txn(16'h0408, 1'b0, 2, 1'b0);
        rd1(16'h0408, "R6 last single write wins", 16'h2222);
        rd1(16'h0409, "R6 neighbour untouched", 16'h0000);

        // R7: burst of five over window 10..12 loops back.
        for (int i = 0; i < 5; i++) wbuf[i] = 16'h00A0 + 16'(i);
        txn(16'h858A, 1'b0, 5, 1'b0);
        txn(16'h858A, 1'b1, 4, 1'b0);
        chk("R7 burst read word 0", rbuf[0], 16'h00A3);
        chk("R7 burst read word 1", rbuf[1], 16'h00A4);
        chk("R7 burst read word 2", rbuf[2], 16'h00A2);
        chk("R7 burst read loops to start", rbuf[3], 16'h00A3);
        chk("R7 drive on every burst read", {15'd0, obuf[3]}, 16'd1);
        rd1(16'h040D, "R7 register past stop untouched", 16'h0000);

        // R8/R9: stop below start wraps via 31 to 0; 30,31 miss channel bank.
        wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333;
        txn(16'hA03E, 1'b0, 3, 1'b0);
        rd1(16'h2000, "R8 wrap through 31 reaches 0", 16'h3333);
        rd1(16'h2001, "R8 no access past the wrap point", 16'h0000);

        // R11: direction flip mid-transaction is ignored.
        wbuf[0] = 16'hBEEF;
        txn(16'h1009, 1'b0, 1, 1'b1);
        chk("R11 no drive on write with flipped wr_n", {15'd0, obuf[0]}, 16'd0);
        rd1(16'h1009, "R11 write still stored", 16'hBEEF);

        // R1: reset in mid-run clears stored state.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd1(16'h7C05, "R1 clear after second reset", 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule